// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block connects an on-chip bus master to one external 512K x 8 asynchronous static RAM. The master raises a one-cycle request with a direction bit, a 19-bit address and, for writes, a data byte. The controller then runs the memory strobes, holding each phase for enough clock cycles to meet the memory's nanosecond timing. It finishes by pulsing a done flag. Read data sits in a register that holds its value until the next read completes.

The memory has no clock. Each timing interval is a parameter in picoseconds, and the clock period is a parameter too. At elaboration each interval is rounded up to whole cycles, with at least one cycle for any non-zero interval. A write takes four phases:

1. Chip select goes low.
2. The write strobe falls while the pad drivers stay off, so the memory's outputs can release.
3. The controller drives the data.
4. Both strobes rise, and the data stays driven for one more cycle.

Because of this sequence, the controller's output drivers never fight the memory's outputs.

Top module: `sram_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the controller goes idle. After that edge, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `done` is 0, whatever `req` does.
- R2: When no transfer is in progress, `mem_ce_n` is 1. Whenever `mem_ce_n` is 1, `mem_oe_n` and `mem_we_n` are also 1.
- R3: A read (`req`=1, `wr`=0 in idle) drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, with `mem_dq_oe`=0, for RD cycles. RD is the largest of the rounded address access, output-enable access and read cycle times, which is 1 cycle at the defaults. On the edge that ends this window, `rdata` takes the byte on `mem_dq_i`, and all strobes return to 1.
- R4: A write (`req`=1, `wr`=1 in idle) first lowers `mem_ce_n` for one cycle with `mem_we_n`=1. It then lowers `mem_we_n`. `mem_oe_n` stays 1 throughout the write, and `mem_we_n` is never 0 while `mem_ce_n` is 1.
- R5: `mem_dq_oe` turns on only after `mem_we_n` has been 0 for HZ cycles (the rounded write-to-high-impedance time, 1 at the defaults) with `mem_oe_n`=1. It turns off in the cycle after `mem_we_n` rises.
- R6: During a write, `mem_dq_o` carries the request's `wdata` for DAT cycles before `mem_we_n` rises (1 at the defaults), and for one more cycle after it rises. DAT covers data setup, the rest of the minimum write pulse and the rest of the write cycle time.
- R7: `mem_addr` takes the request's address on the accepting edge. It stays constant for as long as `mem_ce_n` stays 0.
- R8: `done` is a single-cycle pulse at the end of each transfer. A `req` raised while a transfer is in progress is ignored: the transfer keeps its original address and data, and no second transfer starts.
- R9: `mem_dq_oe` is never 1 while `mem_oe_n` is 0, so the controller never drives the bus while the memory may be driving it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Transfer request, sampled only in idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Byte address |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Last read byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_i | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Pad driver enable for `mem_dq_o` |

## Verification
If the phase register took a wrong value, it would show at the strobe pins within one cycle. Typical symptoms are `mem_we_n` falling without a prior chip-select cycle, or the pad enable rising while output enable is low. A wrong cycle counter would change the length of a strobe window, and the bench checks each write and read phase on its exact cycle. A byte written to the wrong place, or the wrong byte captured, appears at `rdata` on the next read of that address.

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_PS    = 10000,
  parameter int T_AA_PS   = 10000,
  parameter int T_DOE_PS  = 5000,
  parameter int T_RC_PS   = 10000,
  parameter int T_PWE_PS  = 8000,
  parameter int T_SD_PS   = 5000,
  parameter int T_WC_PS   = 10000,
  parameter int T_HZWE_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  function automatic int cycles(input int ps);
    int c;
    c = (ps + CLK_PS - 1) / CLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_CYC  = max2(max2(cycles(T_AA_PS), cycles(T_DOE_PS)), cycles(T_RC_PS));
  localparam int HZ_CYC  = cycles(T_HZWE_PS);
  localparam int DAT_CYC = max2(max2(cycles(T_SD_PS), cycles(T_PWE_PS) - HZ_CYC),
                                max2(cycles(T_WC_PS) - HZ_CYC - 1, 1));
  localparam int MAX_CYC = max2(max2(RD_CYC, HZ_CYC), DAT_CYC);
  localparam int CNT_W   = max2($clog2(MAX_CYC + 1), 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSET, S_WHZ, S_WDAT, S_WHOLD} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  wire              cnt_end = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_ce_n <= 1'b0;
          if (wr) begin
            mem_dq_o <= wdata;
            state    <= S_WSET;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CNT_W'(RD_CYC - 1);
            state    <= S_RD;
          end
        end
        S_RD: if (cnt_end) begin
          rdata    <= mem_dq_i;
          done     <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          state    <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_WSET: begin
          mem_we_n <= 1'b0;
          cnt      <= CNT_W'(HZ_CYC - 1);
          state    <= S_WHZ;
        end
        S_WHZ: if (cnt_end) begin
          mem_dq_oe <= 1'b1;
          cnt       <= CNT_W'(DAT_CYC - 1);
          state     <= S_WDAT;
        end else cnt <= cnt - 1'b1;
        S_WDAT: if (cnt_end) begin
          mem_we_n <= 1'b1;
          mem_ce_n <= 1'b1;
          state    <= S_WHOLD;
        end else cnt <= cnt - 1'b1;
        S_WHOLD: begin
          mem_dq_oe <= 1'b0;
          done      <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe,
  input logic [ADDR_W-1:0] mem_addr
);

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce_n |-> (mem_oe_n && mem_we_n)); // R2

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n); // R4

  AST_CE_BEFORE_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !$past(mem_ce_n)); // R4

  AST_DRIVE_ONLY_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (!mem_we_n && mem_oe_n)); // R5

  AST_RELEASE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe); // R5

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe); // R9

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        done;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  int errors = 0;
  int checks = 0;
  int clashes = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  logic [7:0] mem [256];
  wire mem_drives = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = mem_drives ? mem[mem_addr[7:0]] : 8'h00;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(negedge clk) begin
    if (!mem_ce_n && !mem_we_n && mem_dq_oe) mem[mem_addr[7:0]] <= mem_dq_o;
    if (mem_dq_oe && mem_drives) clashes++;
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    req = 1'b1; wr = 1'b1;
    repeat (3) step();
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !done, "R1 bus/done", {mem_dq_oe, done}, 0);
    req = 1'b0;
    rst_n = 1'b1;
    repeat (2) step();
    chk(mem_ce_n, "R2 idle deselect", mem_ce_n, 1);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d, input bit noisy);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    step();
    req = 1'b0;
    chk(!mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R4 select first",
        {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b0110);
    chk(mem_addr == a, "R7 address", int'(mem_addr), int'(a));
    if (noisy) begin req = 1'b1; wr = 1'b0; addr = a ^ 19'h1; wdata = ~d; end
    step();
    chk(!mem_we_n && mem_oe_n && !mem_dq_oe, "R5 bus released while WE low",
        {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b010);
    step();
    chk(mem_dq_oe && !mem_we_n && mem_oe_n, "R5 drive on", {mem_dq_oe, mem_we_n, mem_oe_n}, 3'b101);
    chk(mem_dq_o == d, "R6 write data", mem_dq_o, d);
    chk(mem_addr == a, "R7 address held", int'(mem_addr), int'(a));
    step();
    if (noisy) req = 1'b0;
    chk(mem_we_n && mem_ce_n && mem_dq_oe && mem_dq_o == d, "R6 data hold",
        {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b111);
    step();
    chk(!mem_dq_oe && done, "R5 release / R8 done", {mem_dq_oe, done}, 2'b01);
    step();
    chk(!done && mem_ce_n, "R8 done one cycle", {done, mem_ce_n}, 2'b01);
  endtask

  task automatic t_read(input logic [18:0] a, input logic [7:0] e);
    req = 1'b1; wr = 1'b0; addr = a;
    step();
    req = 1'b0;
    chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe, "R3 read strobes",
        {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0010);
    chk(mem_addr == a, "R7 read address", int'(mem_addr), int'(a));
    step();
    chk(done && rdata == e, "R3 read data", rdata, e);
    chk(mem_ce_n && mem_oe_n, "R2 deselect after read", {mem_ce_n, mem_oe_n}, 3);
    step();
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  initial begin
    t_reset();
    t_read(19'h00010, 8'h10 ^ 8'h5A);
    t_write(19'h40021, 8'hA5, 1'b0);
    t_read(19'h40021, 8'hA5);
    t_write(19'h00033, 8'h00, 1'b0);
    t_write(19'h7FFFF, 8'hFF, 1'b0);
    t_read(19'h00033, 8'h00);
    t_read(19'h7FFFF, 8'hFF);
    t_write(19'h00044, 8'h3C, 1'b1);
    t_read(19'h00044, 8'h3C);
    t_read(19'h00045, 8'h45 ^ 8'h5A); // R8 ignored request left neighbour untouched
    chk(clashes == 0, "R9 no bus contention", clashes, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule